// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block watches the bytes of each received frame as they stream past, one byte per accepted cycle, and decides whether the frame should be timestamped. Each frame gets one decision. The decision is issued at the earliest byte where the outcome is known. It is a one-cycle strobe, and a match flag beside it says whether the frame qualifies. A timestamp unit placed beside the receive path uses the pair to keep or drop the time it captured at the start of the frame.

A three-bit mode field selects the rule:

- **Off**: nothing is stamped.
- **Version-1 Sync**: only version-1 Sync messages carried over UDP are stamped.
- **Version-1 Delay request**: only version-1 Delay request messages carried over UDP are stamped.
- **Version-2 event**: version-2 event messages are stamped, whether carried directly over Ethernet or over UDP.
- **All**: every frame is stamped.

Two filters serve the header-based modes:

- **Ethernet filter**: compares the EtherType with a programmed value. It takes effect only when both its enable bit and its stamp bit are set.
- **UDP filter**: requires IPv4, protocol UDP and a programmed destination port. It can optionally require the same value in the source port.

One 802.1Q tag is recognised, and the IPv4 header length is taken from the header itself.

Top module: `ptp_event_classifier`

## Requirements
- R1: Mode code 0 (off) and the unused codes 5, 6 and 7 give one strobe with the match flag low. The strobe comes in the cycle after the first byte of a frame.
- R2: Mode code 4 (all) gives one strobe with the match flag high in the cycle after the first byte of every frame, whatever its contents.
- R3: In mode code 3 (version-2 event), a frame whose EtherType (bytes 12-13, big-endian) equals the programmed value is decided on its first payload byte. This needs both Ethernet filter bits set. The frame matches when that byte's low nibble is 3 or less.
- R4: If either Ethernet filter bit is clear, a frame carrying the programmed EtherType is rejected on the second EtherType byte, unless that EtherType is 0x0800.
- R5: The UDP path requires EtherType 0x0800, an IP version nibble of 4, an IHL of 5 or more, protocol byte 17 (IP header byte 9) and a UDP destination port equal to the programmed port. A frame that fails any check is rejected on the last byte of the first failing field.
- R6: With the source-port check on, the UDP source port must also equal the programmed port, or the frame is rejected on the second source-port byte. With the check off, the source port is ignored.
- R7: With the UDP filter disabled, an IPv4 frame is rejected on the second EtherType byte in every header-based mode.
- R8: In mode 3 over UDP, the decision falls on the first PTP byte (UDP header start + 8). The frame matches when that byte's low nibble is 3 or less.
- R9: In modes 1 and 2, the decision falls on the version-1 control byte at PTP offset 32. Mode 1 matches control value 0 and mode 2 matches control value 1.
- R10: A tag type 0x8100 at bytes 12-13 moves the EtherType and all later fields 4 bytes further into the frame.
- R11: An IHL above 5 moves the UDP header and the PTP fields to IP start + 4×IHL.
- R12: A frame that ends before its deciding byte gives no strobe. A frame gives at most one strobe. Bytes arriving after an end-of-frame and before the next start-of-frame are ignored.
- R13: During and after reset both outputs are low. A decision appears exactly one cycle after the deciding byte is accepted, including when the input has idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Byte present this cycle |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| cfg_mode | input | 3 | 0 off, 1 v1 Sync, 2 v1 Delay request, 3 v2 event, 4 all |
| cfg_l2_en | input | 1 | Ethernet filter enable |
| cfg_l2_stamp | input | 1 | Ethernet filter stamp enable |
| cfg_l2_etype | input | 16 | EtherType to match |
| cfg_l4_en | input | 1 | UDP filter enable |
| cfg_l4_port | input | 16 | UDP event port |
| cfg_l4_srcchk | input | 1 | Also require source port match |
| ts_strobe | output | 1 | One-cycle decision strobe |
| ts_match | output | 1 | Frame should be timestamped (valid with strobe) |

## Verification
Frames are built field by field, and several patterns are used to tell the classification cases apart:

- **Ethernet event and general message types**: separate a correct decision byte from a wrong nibble test.
- **Tagged and untagged frames, and frames with a longer IP header**: expose any offset held fixed instead of derived from the header.
- **One field at a time broken** (protocol, destination port, source port, IHL, filter bits): shows that each check fires on its own byte.
- **The same UDP frame replayed under the two version-1 modes**: shows that the control code follows the mode.
- **Truncated frames, stray bytes between frames, and idle gaps inside frames**: probe the once-per-frame rule and the cycle of the strobe.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;

   typedef enum logic [2:0] {
      MODE_OFF     = 3'd0,
      MODE_V1_SYNC = 3'd1,
      MODE_V1_DREQ = 3'd2,
      MODE_V2_EVT  = 3'd3,
      MODE_ALL     = 3'd4
   } cls_mode_e;

   typedef enum logic [1:0] {
      ST_ETH,
      ST_L2,
      ST_IP,
      ST_DONE
   } cls_state_e;

   localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
   localparam logic [15:0] TAG_TPID    = 16'h8100;
   localparam logic [7:0]  PROTO_UDP   = 8'd17;
   localparam int          ETYPE_POS   = 12;
   localparam int          TAG_BYTES   = 4;
   localparam int          IP_HDR_MAX  = 60;
   localparam int          UDP_HDR     = 8;

endpackage

// File: rtl/ptp_cls_pos.sv
module ptp_cls_pos #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   output logic             take,
   output logic [CNT_W-1:0] idx
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;

   assign take = in_valid && (in_sop || active_q);
   assign idx  = in_sop ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (take) begin
         active_q <= !in_eop;
         cnt_q    <= (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;
      end
   end

endmodule

// File: rtl/ptp_cls_engine.sv
module ptp_cls_engine
   import ptp_cls_pkg::*;
#(
   parameter int          CNT_W        = 7,
   parameter bit          VLAN_EN      = 1'b1,
   parameter int          V1_CTRL_OFS  = 32,
   parameter logic [7:0]  V1_SYNC_CODE = 8'd0,
   parameter logic [7:0]  V1_DREQ_CODE = 8'd1,
   parameter logic [3:0]  EVT_TYPE_MAX = 4'd3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             in_sop,
   input  logic [CNT_W-1:0] idx,
   input  logic [7:0]       in_data,
   input  logic [2:0]       cfg_mode,
   input  logic             cfg_l2_en,
   input  logic             cfg_l2_stamp,
   input  logic [15:0]      cfg_l2_etype,
   input  logic             cfg_l4_en,
   input  logic [15:0]      cfg_l4_port,
   input  logic             cfg_l4_srcchk,
   output logic             ts_strobe,
   output logic             ts_match
);

   localparam logic [CNT_W-1:0] E_BASE   = CNT_W'(ETYPE_POS);
   localparam logic [CNT_W-1:0] E_TAGGED = CNT_W'(ETYPE_POS + TAG_BYTES);
   localparam logic [CNT_W-1:0] K1       = CNT_W'(1);
   localparam logic [CNT_W-1:0] K2       = CNT_W'(2);
   localparam logic [CNT_W-1:0] K3       = CNT_W'(3);
   localparam logic [CNT_W-1:0] K_PROTO  = CNT_W'(9);
   localparam logic [CNT_W-1:0] K_PTP    = CNT_W'(UDP_HDR);
   localparam logic [CNT_W-1:0] K_CTRL   = CNT_W'(UDP_HDR + V1_CTRL_OFS);

   cls_state_e       st_q, cur_st, nst;
   logic [CNT_W-1:0] eoff_q, cur_eoff, n_eoff;
   logic [CNT_W-1:0] uofs_q, n_uofs;
   logic [7:0]       prev_q;
   logic [15:0]      word;
   logic [CNT_W-1:0] pay;
   logic             is_tag;
   logic             hdr_mode;
   logic             dec, dmatch;
   logic [7:0]       v1_code;

   assign word     = {prev_q, in_data};
   assign cur_st   = in_sop ? ST_ETH : st_q;
   assign cur_eoff = in_sop ? E_BASE : eoff_q;
   assign pay      = cur_eoff + K2;
   assign hdr_mode = (cfg_mode == MODE_V1_SYNC) || (cfg_mode == MODE_V1_DREQ) ||
                     (cfg_mode == MODE_V2_EVT);
   assign v1_code  = (cfg_mode == MODE_V1_SYNC) ? V1_SYNC_CODE : V1_DREQ_CODE;

   generate
      if (VLAN_EN) begin : g_tag
         assign is_tag = (cur_eoff == E_BASE) && (word == TAG_TPID);
      end else begin : g_notag
         assign is_tag = 1'b0;
      end
   endgenerate

   always_comb begin
      dec    = 1'b0;
      dmatch = 1'b0;
      nst    = cur_st;
      n_eoff = cur_eoff;
      n_uofs = uofs_q;
      if (take) begin
         if (!hdr_mode) begin
            if (idx == '0) begin
               dec    = 1'b1;
               dmatch = (cfg_mode == MODE_ALL);
            end
         end else begin
            unique case (cur_st)
               ST_ETH: begin
                  if (idx == cur_eoff + K1) begin
                     if (is_tag) begin
                        n_eoff = E_TAGGED;
                     end else if ((cfg_mode == MODE_V2_EVT) && cfg_l2_en && cfg_l2_stamp &&
                                  (word == cfg_l2_etype)) begin
                        nst = ST_L2;
                     end else if ((word == ETYPE_IPV4) && cfg_l4_en) begin
                        nst = ST_IP;
                     end else begin
                        dec = 1'b1;
                     end
                  end
               end
               ST_L2: begin
                  if (idx == pay) begin
                     dec    = 1'b1;
                     dmatch = (in_data[3:0] <= EVT_TYPE_MAX);
                  end
               end
               ST_IP: begin
                  if (idx == pay) begin
                     if ((in_data[7:4] != 4'd4) || (in_data[3:0] < 4'd5)) dec = 1'b1;
                     else n_uofs = pay + CNT_W'({in_data[3:0], 2'b00});
                  end else if (idx == pay + K_PROTO) begin
                     if (in_data != PROTO_UDP) dec = 1'b1;
                  end else if (idx == uofs_q + K1) begin
                     if (cfg_l4_srcchk && (word != cfg_l4_port)) dec = 1'b1;
                  end else if (idx == uofs_q + K3) begin
                     if (word != cfg_l4_port) dec = 1'b1;
                  end else if ((cfg_mode == MODE_V2_EVT) && (idx == uofs_q + K_PTP)) begin
                     dec    = 1'b1;
                     dmatch = (in_data[3:0] <= EVT_TYPE_MAX);
                  end else if ((cfg_mode != MODE_V2_EVT) && (idx == uofs_q + K_CTRL)) begin
                     dec    = 1'b1;
                     dmatch = (in_data == v1_code);
                  end
               end
               default: ;
            endcase
         end
         if (dec) nst = ST_DONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_DONE;
         eoff_q    <= E_BASE;
         uofs_q    <= '0;
         prev_q    <= '0;
         ts_strobe <= 1'b0;
         ts_match  <= 1'b0;
      end else begin
         ts_strobe <= dec;
         ts_match  <= dec && dmatch;
         if (take) begin
            st_q   <= nst;
            eoff_q <= n_eoff;
            uofs_q <= n_uofs;
            prev_q <= in_data;
         end
      end
   end

endmodule

// File: rtl/ptp_event_classifier.sv
module ptp_event_classifier
   import ptp_cls_pkg::*;
#(
   parameter bit          VLAN_EN      = 1'b1,
   parameter int          V1_CTRL_OFS  = 32,
   parameter logic [7:0]  V1_SYNC_CODE = 8'd0,
   parameter logic [7:0]  V1_DREQ_CODE = 8'd1,
   parameter logic [3:0]  EVT_TYPE_MAX = 4'd3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_sop,
   input  logic        in_eop,
   input  logic [7:0]  in_data,
   input  logic [2:0]  cfg_mode,
   input  logic        cfg_l2_en,
   input  logic        cfg_l2_stamp,
   input  logic [15:0] cfg_l2_etype,
   input  logic        cfg_l4_en,
   input  logic [15:0] cfg_l4_port,
   input  logic        cfg_l4_srcchk,
   output logic        ts_strobe,
   output logic        ts_match
);

   localparam int MAX_POS = ETYPE_POS + (VLAN_EN ? TAG_BYTES : 0) + 2 + IP_HDR_MAX +
                            UDP_HDR + V1_CTRL_OFS;
   localparam int CNT_W   = $clog2(MAX_POS + 2);

   generate
      if (V1_CTRL_OFS < 1 || V1_CTRL_OFS > 200) begin : g_bad_ofs
         $error("V1_CTRL_OFS out of supported range");
      end
      if (V1_SYNC_CODE == V1_DREQ_CODE) begin : g_bad_code
         $error("version-1 message codes must differ");
      end
   endgenerate

   logic             take;
   logic [CNT_W-1:0] idx;

   ptp_cls_pos #(.CNT_W(CNT_W)) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .take     (take),
      .idx      (idx)
   );

   ptp_cls_engine #(
      .CNT_W        (CNT_W),
      .VLAN_EN      (VLAN_EN),
      .V1_CTRL_OFS  (V1_CTRL_OFS),
      .V1_SYNC_CODE (V1_SYNC_CODE),
      .V1_DREQ_CODE (V1_DREQ_CODE),
      .EVT_TYPE_MAX (EVT_TYPE_MAX)
   ) u_eng (
      .clk           (clk),
      .rst_n         (rst_n),
      .take          (take),
      .in_sop        (in_sop),
      .idx           (idx),
      .in_data       (in_data),
      .cfg_mode      (cfg_mode),
      .cfg_l2_en     (cfg_l2_en),
      .cfg_l2_stamp  (cfg_l2_stamp),
      .cfg_l2_etype  (cfg_l2_etype),
      .cfg_l4_en     (cfg_l4_en),
      .cfg_l4_port   (cfg_l4_port),
      .cfg_l4_srcchk (cfg_l4_srcchk),
      .ts_strobe     (ts_strobe),
      .ts_match      (ts_match)
   );

endmodule

// File: rtl/ptp_cls_chk.sv
module ptp_cls_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_sop,
   input logic [2:0] cfg_mode,
   input logic       cfg_l4_en,
   input logic       ts_strobe,
   input logic       ts_match
);

   logic sop_d;
   logic had_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sop_d <= 1'b0;
         had_q <= 1'b0;
      end else begin
         sop_d <= in_valid && in_sop;
         had_q <= sop_d ? ts_strobe : (had_q || ts_strobe);
      end
   end

   // R12: never a second decision inside one frame
   a_r12_one_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_strobe && !sop_d) |-> !had_q);

   // R12: a decision always follows an accepted byte
   a_r12_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      ts_strobe |-> $past(in_valid));

   // R13: match flag is only meaningful together with the strobe
   a_r13_match_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ts_match |-> ts_strobe);

   // R1: off mode decides on the first byte, without a match
   a_r1_off_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && cfg_mode == 3'd0) |=> (ts_strobe && !ts_match));

   // R2: all mode decides on the first byte, with a match
   a_r2_all_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && cfg_mode == 3'd4) |=> (ts_strobe && ts_match));

   // R7: version-1 modes only match through the UDP filter
   a_r7_v1_needs_l4: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_match && ($past(cfg_mode) == 3'd1 || $past(cfg_mode) == 3'd2)) |-> $past(cfg_l4_en));

endmodule

bind ptp_event_classifier ptp_cls_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sop    (in_sop),
   .cfg_mode  (cfg_mode),
   .cfg_l4_en (cfg_l4_en),
   .ts_strobe (ts_strobe),
   .ts_match  (ts_match)
);

// File: tb/ptp_event_classifier_tb.sv
module ptp_event_classifier_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_sop, in_eop;
   logic [7:0]  in_data;
   logic [2:0]  cfg_mode;
   logic        cfg_l2_en, cfg_l2_stamp, cfg_l4_en, cfg_l4_srcchk;
   logic [15:0] cfg_l2_etype, cfg_l4_port;
   logic        ts_strobe, ts_match;

   always #10 clk = ~clk;

   ptp_event_classifier u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
      .in_data(in_data), .cfg_mode(cfg_mode), .cfg_l2_en(cfg_l2_en),
      .cfg_l2_stamp(cfg_l2_stamp), .cfg_l2_etype(cfg_l2_etype), .cfg_l4_en(cfg_l4_en),
      .cfg_l4_port(cfg_l4_port), .cfg_l4_srcchk(cfg_l4_srcchk),
      .ts_strobe(ts_strobe), .ts_match(ts_match));

   int    n_vec = 0;
   int    n_bad = 0;
   bit    finished = 0;
   logic  pend_s = 1'b0, pend_m = 1'b0;
   string pend_tag = "R13";
   logic [7:0] fr[$];

   task automatic compare();
      n_vec++;
      if (ts_strobe !== pend_s || ts_match !== pend_m) begin
         n_bad++;
         $display("FAIL %s: strobe/match = %b/%b, expected %b/%b at %0t",
                  pend_tag, ts_strobe, ts_match, pend_s, pend_m, $time);
      end
   endtask

   task automatic cyc(input logic v, input logic s, input logic e, input logic [7:0] d,
                      input logic xs, input logic xm, input string tag);
      @(negedge clk);
      compare();
      in_valid = v; in_sop = s; in_eop = e; in_data = d;
      pend_s = xs; pend_m = xm; pend_tag = tag;
   endtask

   // behavioural reference: deciding byte index (-1 none) and match
   function automatic void model(output int di, output bit dm);
      int len = fr.size();
      int e, p, ihl, u, q;
      logic [15:0] et;
      di = -1; dm = 0;
      if (len == 0) return;
      if (!(cfg_mode inside {3'd1, 3'd2, 3'd3})) begin
         di = 0; dm = (cfg_mode == 3'd4); return;
      end
      e = 12;
      if (len >= 14 && {fr[12], fr[13]} == 16'h8100) e = 16;
      if (len < e + 2) return;
      et = {fr[e], fr[e+1]};
      p = e + 2;
      if (cfg_mode == 3'd3 && cfg_l2_en && cfg_l2_stamp && et == cfg_l2_etype) begin
         if (len > p) begin di = p; dm = (fr[p][3:0] <= 4'd3); end
         return;
      end
      if (!(et == 16'h0800 && cfg_l4_en)) begin di = e + 1; return; end
      if (len <= p) return;
      ihl = fr[p][3:0];
      if (fr[p][7:4] != 4'd4 || ihl < 5) begin di = p; return; end
      if (len <= p + 9) return;
      if (fr[p+9] != 8'd17) begin di = p + 9; return; end
      u = p + 4 * ihl;
      if (len <= u + 1) return;
      if (cfg_l4_srcchk && {fr[u], fr[u+1]} != cfg_l4_port) begin di = u + 1; return; end
      if (len <= u + 3) return;
      if ({fr[u+2], fr[u+3]} != cfg_l4_port) begin di = u + 3; return; end
      q = u + 8;
      if (cfg_mode == 3'd3) begin
         if (len > q) begin di = q; dm = (fr[q][3:0] <= 4'd3); end
         return;
      end
      if (len > q + 32) begin
         di = q + 32;
         dm = (fr[q+32] == ((cfg_mode == 3'd1) ? 8'd0 : 8'd1));
      end
   endfunction

   task automatic fill(input int len);
      fr.delete();
      for (int i = 0; i < len; i++) fr.push_back(8'((i * 37 + 5) & 255));
   endtask

   task automatic mk_l2(input bit tag, input logic [15:0] et, input logic [7:0] b0, input int len);
      int e = 12;
      fill(len);
      if (tag) begin fr[12] = 8'h81; fr[13] = 8'h00; e = 16; end
      fr[e] = et[15:8]; fr[e+1] = et[7:0]; fr[e+2] = b0;
   endtask

   task automatic mk_udp(input bit tag, input int ihl, input logic [7:0] proto,
                         input logic [15:0] sp, input logic [15:0] dp,
                         input logic [7:0] b0, input logic [7:0] ctrl, input int len);
      int e = 12;
      int p, u;
      fill(len);
      if (tag) begin fr[12] = 8'h81; fr[13] = 8'h00; e = 16; end
      fr[e] = 8'h08; fr[e+1] = 8'h00;
      p = e + 2;
      fr[p] = {4'h4, 4'(ihl)};
      fr[p+9] = proto;
      u = p + 4 * ((ihl < 5) ? 5 : ihl);
      fr[u] = sp[15:8]; fr[u+1] = sp[7:0]; fr[u+2] = dp[15:8]; fr[u+3] = dp[7:0];
      if (u + 8 < len) fr[u+8] = b0;
      if (u + 40 < len) fr[u+40] = ctrl;
   endtask

   task automatic send(input string tag, input bit gaps);
      int di;
      bit dm;
      model(di, dm);
      for (int i = 0; i < fr.size(); i++) begin
         cyc(1'b1, i == 0, i == fr.size() - 1, fr[i], i == di, (i == di) && dm, tag);
         if (gaps && (i % 3 == 1)) cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
      end
      cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h00;
      cfg_mode = 3'd3; cfg_l2_en = 1'b1; cfg_l2_stamp = 1'b1; cfg_l2_etype = 16'h88F7;
      cfg_l4_en = 1'b1; cfg_l4_port = 16'd319; cfg_l4_srcchk = 1'b0;
      // R13: outputs stay low while reset is held, even with bytes offered
      cyc(1'b1, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0, "R13");
      cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R13");
      cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R13");
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R13");

      // version-2 event over Ethernet
      mk_l2(0, 16'h88F7, 8'h10, 60);  send("R3 event type", 0);
      mk_l2(0, 16'h88F7, 8'h08, 60);  send("R3 general type", 0);
      mk_l2(1, 16'h88F7, 8'h03, 64);  send("R10 tagged R3", 1);
      cfg_l2_stamp = 1'b0;
      mk_l2(0, 16'h88F7, 8'h00, 60);  send("R4 stamp bit off", 0);
      cfg_l2_stamp = 1'b1; cfg_l2_en = 1'b0;
      mk_l2(0, 16'h88F7, 8'h00, 60);  send("R4 enable bit off", 0);
      cfg_l2_en = 1'b1;

      // version-2 event over UDP
      mk_udp(1, 5, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 80); send("R8 R10 tagged udp", 0);
      mk_udp(0, 5, 8'd17, 16'd319, 16'd319, 8'h0B, 8'h00, 80); send("R8 general over udp", 1);

      // version-1 modes
      cfg_mode = 3'd1;
      mk_udp(0, 5, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 100); send("R9 sync in sync mode", 0);
      mk_udp(0, 5, 8'd17, 16'd319, 16'd319, 8'h01, 8'h01, 100); send("R9 dreq in sync mode", 0);
      cfg_mode = 3'd2;
      mk_udp(0, 5, 8'd17, 16'd319, 16'd319, 8'h01, 8'h01, 100); send("R9 dreq in dreq mode", 0);
      mk_udp(0, 5, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 100); send("R9 sync in dreq mode", 0);
      cfg_mode = 3'd1;
      mk_udp(0, 7, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 110); send("R11 long ip header", 1);
      mk_udp(1, 6, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 110); send("R11 R10 tag and options", 0);

      // source port check
      cfg_l4_srcchk = 1'b1;
      mk_udp(0, 5, 8'd17, 16'd320, 16'd319, 8'h01, 8'h00, 100); send("R6 src mismatch", 0);
      mk_udp(0, 5, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 100); send("R6 src match", 0);
      cfg_l4_srcchk = 1'b0;
      mk_udp(0, 5, 8'd17, 16'd320, 16'd319, 8'h01, 8'h00, 100); send("R6 src ignored", 0);

      // header rejections
      mk_udp(0, 5, 8'd6,  16'd319, 16'd319, 8'h01, 8'h00, 100); send("R5 protocol", 0);
      mk_udp(0, 5, 8'd17, 16'd319, 16'd320, 8'h01, 8'h00, 100); send("R5 dest port", 0);
      mk_udp(0, 4, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 100); send("R5 short ihl", 0);
      mk_l2(0, 16'h86DD, 8'h00, 60); send("R5 other ethertype", 0);

      // UDP filter disabled
      cfg_l4_en = 1'b0;
      mk_udp(0, 5, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 100); send("R7 l4 off v1", 0);
      cfg_mode = 3'd3;
      mk_udp(0, 5, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 100); send("R7 l4 off v2", 0);
      cfg_l4_en = 1'b1; cfg_mode = 3'd1;

      // runts and stray bytes
      mk_udp(0, 5, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 60); send("R12 runt before ctrl", 0);
      mk_l2(0, 16'h88F7, 8'h00, 13); send("R12 runt before etype", 0);
      for (int i = 0; i < 20; i++)
         cyc(1'b1, 1'b0, 1'b0, 8'(i), 1'b0, 1'b0, "R12 stray bytes");
      cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R12 stray bytes");

      // off / all / unused codes
      cfg_mode = 3'd4;
      fill(3); send("R2 all short", 0);
      fill(1); send("R2 all single byte", 0);
      mk_l2(0, 16'h1234, 8'h00, 40); send("R2 all any header", 1);
      cfg_mode = 3'd0;
      mk_udp(0, 5, 8'd17, 16'd319, 16'd319, 8'h01, 8'h00, 100); send("R1 off", 0);
      cfg_mode = 3'd6;
      mk_l2(0, 16'h88F7, 8'h00, 30); send("R1 unused code", 0);

      repeat (3) cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R13 idle");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule